// File: doc/BRIEF.md
# Burst address generator

This block captures an external word address when a burst begins and then supplies the address for each of the four beats of that burst. Either of two active-low start strobes begins a burst. One strobe comes from a processor and the other from a cache controller, and they have equal standing. After the start, an active-low advance input steps through the beats. While advance is high, the current beat is held, which suspends the burst.

Only the two least significant address bits change during a burst. The bits above them keep the value captured at the start. A mode input selects the beat order. Low selects linear order, which counts upward modulo four. High selects interleaved order, in which the starting low bits are XORed with the beat count. A new address may be loaded on any cycle, so a user that never advances gets plain registered single-word addressing. The mode input acts on the output directly and is meant to be held steady during a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: When `proc_stb_n` or `ctrl_stb_n` is low at a rising clock edge, `addr_in` is captured. From the next cycle on, `addr_out` equals the captured address and `last_beat` is 0.
- R2: Bits `addr_out[ADDR_W-1:2]` do not change on any edge where neither strobe is low, even if `addr_in` changes.
- R3: With `order_ilv` = 0, each advance (`adv_n` low, no strobe) sets the low two bits to the previous low bits plus one, modulo 4. A start of 01 gives 01, 10, 11, 00.
- R4: With `order_ilv` = 1, beat k has low bits equal to the starting low bits XOR k. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R5: `last_beat` is 1 exactly on the fourth beat (beat index 3). One more advance returns `addr_out` to the starting address, with `last_beat` at 0.
- R6: On an edge with no strobe low and `adv_n` high, `addr_out` and `last_beat` keep their values.
- R7: A strobe overrides `adv_n` in the same cycle. Loads on back-to-back cycles each show the newly loaded address.
- R8: After reset, `addr_out` is 0 and `last_beat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_stb_n | input | 1 | Processor start strobe, active low |
| ctrl_stb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low; high holds |
| order_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Address for the current beat |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
A corrupted beat counter appears on the low bits of `addr_out` one cycle after the advance that corrupted it. It also shifts `last_beat` off the fourth beat, so walking a full burst plus one wrap beat in both orders shows the fault within five cycles. A corrupted captured start value or upper field appears on the first cycle after the load. Such faults are checked by comparing each beat with the expected value and by holding the burst while `addr_in` is changed.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bag_start_qual.sv
module bag_start_qual (
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    output logic start
);
    // Either strobe begins a burst; both have equal standing.
    always_comb start = !proc_stb_n || !ctrl_stb_n;
endmodule

// File: rtl/bag_beat_map.sv
module bag_beat_map
    import bag_pkg::*;
(
    input  beat_t base,
    input  beat_t count,
    input  logic  ilv,
    output beat_t beat
);
    beat_t lin_beat;
    beat_t ilv_beat;

    always_comb begin
        lin_beat = beat_t'(base + count);
        ilv_beat = base ^ count;
        beat     = ilv ? ilv_beat : lin_beat;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last_beat
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        beat_t           lo;
        beat_t           cnt;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    start;
    beat_t   beat_lo;

    bag_start_qual u_qual (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .start      (start)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.hi  = addr_in[ADDR_W-1:BEAT_W];
            st_d.lo  = addr_in[BEAT_W-1:0];
            st_d.cnt = '0;
        end else if (!adv_n) begin
            st_d.cnt = beat_t'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bag_beat_map u_map (
        .base  (st_q.lo),
        .count (st_q.cnt),
        .ilv   (order_ilv),
        .beat  (beat_lo)
    );

    always_comb begin
        addr_out  = {st_q.hi, beat_lo};
        last_beat = &st_q.cnt;
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n || !ctrl_stb_n) |=> (addr_out == $past(addr_in)) && !last_beat); // R1
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && ctrl_stb_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && ctrl_stb_n && !adv_n && !order_ilv) |=>
        (order_ilv || addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + 1'b1))); // R3
    AST_WRAP_CLEARS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && proc_stb_n && ctrl_stb_n && !adv_n) |=> !last_beat); // R5
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_stb_n && ctrl_stb_n && adv_n) |=> ($stable(last_beat) &&
        (order_ilv != $past(order_ilv) || $stable(addr_out)))); // R6
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              proc_stb_n = 1'b1;
    logic              ctrl_stb_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              order_ilv = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              last_beat;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .order_ilv  (order_ilv),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .last_beat  (last_beat)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [ADDR_W-1:0] got_a,
                       input logic [ADDR_W-1:0] exp_a, input logic got_l, input logic exp_l);
        n_run++;
        if (got_a !== exp_a || got_l !== exp_l) begin
            n_fail++;
            $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                     req, got_a, got_l, exp_a, exp_l);
        end
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input bit use_ctrl);
        addr_in = a;
        adv_n = 1'b1;
        if (use_ctrl) ctrl_stb_n = 1'b0; else proc_stb_n = 1'b0;
        tick();
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b1;
    endtask

    function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] s,
                                                   input logic ilv, input int k);
        logic [1:0] kk;
        logic [1:0] lo;
        kk = 2'(k);
        lo = ilv ? (s[1:0] ^ kk) : 2'(s[1:0] + kk);
        return {s[ADDR_W-1:2], lo};
    endfunction

    // R1 R3 R4 R5: full burst plus the wrap beat
    task automatic t_burst(input string req, input logic ilv,
                           input logic [ADDR_W-1:0] s, input bit use_ctrl);
        order_ilv = ilv;
        load(s, use_ctrl);
        chk({req, " R1 load"}, addr_out, s, last_beat, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            addr_in = ~addr_in;
            tick();
            chk((k == 4) ? {req, " R5 wrap"} : req, addr_out, beat_addr(s, ilv, k),
                last_beat, (k == 3));
        end
        adv_n = 1'b1;
    endtask

    // R6 and R2: suspend holds while addr_in wanders
    task automatic t_suspend();
        logic [ADDR_W-1:0] s;
        s = 17'h0A5E5;
        order_ilv = 1'b0;
        load(s, 1'b0);
        adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            addr_in = 17'h1FFFF - 17'(k);
            tick();
            chk("R6 suspend hold / R2 upper", addr_out, beat_addr(s, 1'b0, 1),
                last_beat, 1'b0);
        end
        adv_n = 1'b0;
        tick();
        tick();
        chk("R6 resume after suspend", addr_out, beat_addr(s, 1'b0, 3), last_beat, 1'b1);
        adv_n = 1'b1;
    endtask

    // R7: strobe beats advance, loads each cycle
    task automatic t_priority();
        order_ilv = 1'b1;
        load(17'h00013, 1'b1);
        adv_n = 1'b0;
        tick();
        tick();
        adv_n = 1'b0;
        addr_in = 17'h12346;
        proc_stb_n = 1'b0;
        tick();
        chk("R7 strobe over advance", addr_out, 17'h12346, last_beat, 1'b0);
        addr_in = 17'h0F0F1;
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b0;
        tick();
        chk("R7 back-to-back load", addr_out, 17'h0F0F1, last_beat, 1'b0);
        addr_in = 17'h00002;
        ctrl_stb_n = 1'b0;
        proc_stb_n = 1'b0;
        tick();
        chk("R7 third load", addr_out, 17'h00002, last_beat, 1'b0);
        proc_stb_n = 1'b1;
        ctrl_stb_n = 1'b1;
        adv_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 2 + 3);
        chk("R8 reset", addr_out, '0, last_beat, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R8 after release", addr_out, '0, last_beat, 1'b0);
        t_burst("R3 linear 01", 1'b0, 17'h1C001, 1'b0);
        t_burst("R3 linear 11", 1'b0, 17'h00047, 1'b1);
        t_burst("R4 interleaved 01", 1'b1, 17'h15555, 1'b1);
        t_burst("R4 interleaved 10", 1'b1, 17'h0ABCE, 1'b0);
        t_suspend();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule